// File: doc/BRIEF.md
# Two-channel cycle-steal DMA controller

This block moves data between two addresses on a bus it shares with a processor. Two independent channels each keep a 20-bit source base, a 20-bit destination base, a running forward offset, a 16-bit transfer counter and its reload value. A channel is started either by software writing its trigger register or by a rising edge on one peripheral interrupt line. That line is chosen per channel and is watched regardless of any interrupt masking. The block never drives or clears any interrupt flag.

Each accepted request moves one unit, a byte or a 16-bit word. The controller raises a bus request and waits for the grant. It then steals exactly two cycles: one read cycle that fills an internal latch made of a low and a high byte, and one write cycle that drives the latch out. After that it releases the bus. Requests that arrive while one is already waiting merge into a single transfer. A channel stops by itself when its counter runs out, unless it is set to repeat.

Top module: `dmac_top`

## Requirements
- R1: While reset is held and right after it, bus_req, bus_rd and bus_wr are low and both ch_en bits are 0.
- R2: A write with cfg_we high goes to the channel given by cfg_ch. The register is picked by cfg_sel: 0 source base, 1 destination base, 2 reload value (this also loads the counter), 3 control, 4 software trigger. A write with code 0, 1 or 2 clears the forward offset. The control bits are: bit0 enable, bit1 word mode, bit2 source increment, bit3 destination increment, bit4 repeat, bits 7:5 interrupt line select. ch_en shows the enable bits.
- R3: After a request, bus_req rises and nothing is read or written while bus_grant is low. Once granted, there is exactly one read cycle (bus_rd) at the source address, then one write cycle (bus_wr) at the destination address. bus_req then falls.
- R4: In word mode the 16 bits read are written unchanged. In byte mode bus_wdata[7:0] carries bus_rdata[7:0] and bus_wdata[15:8] is zero. bus_word shows the mode.
- R5: The source address is base plus forward offset when source increment is set, and the base alone otherwise. The same rule applies to the destination. After each transfer that does not underflow, the offset grows by 2 in word mode and by 1 in byte mode, if either increment bit is set.
- R6: A reload value of N gives N+1 transfers. A transfer that finds the counter at 0 reloads the counter and clears the offset. It also clears the enable bit unless repeat is set. Any other transfer decrements the counter.
- R7: A request is a trigger-register write or a rising edge on the selected irq_in line. Edges on other lines are ignored. A request made while the channel is disabled is dropped and is not remembered.
- R8: When both channels are waiting at the same time, channel 0 is served first.
- R9: Extra requests for a channel that is still waiting for the bus merge into one. A channel's waiting flag clears at the cycle its grant is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 1 | Channel addressed by the write |
| cfg_sel | input | 3 | Register code (see R2) |
| cfg_wdata | input | 20 | Write data |
| irq_in | input | 8 | Peripheral interrupt lines |
| bus_gnt | input | 1 | Bus grant from the processor side |
| bus_rdata | input | 16 | Read data returned in the read cycle |
| bus_req | output | 1 | Bus request, held through the transfer |
| bus_rd | output | 1 | Read cycle strobe |
| bus_wr | output | 1 | Write cycle strobe |
| bus_word | output | 1 | 1 for a 16-bit unit, 0 for a byte |
| bus_addr | output | 20 | Address for the read or write cycle |
| bus_wdata | output | 16 | Latched data for the write cycle |
| ch_en | output | 2 | Enable bit of each channel |

## Verification
A bad forward offset or a bad counter shows up at the next write cycle as a wrong bus_addr, or as the wrong number of transfers before ch_en drops. These errors show within four cycles of the trigger when the grant is held high. A waiting flag stuck low shows as a missing bus_req one cycle after a trigger. A flag stuck high shows as an extra transfer, which the scoreboard pops from an empty queue. Wrong arbitration swaps the order of two queued writes and is caught at the first one.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int DMA_AW   = 20;
    localparam int DMA_CW   = 16;
    localparam int DMA_IRQN = 8;
    localparam int DMA_NCH  = 2;

    localparam logic [2:0] RG_SRC  = 3'd0;
    localparam logic [2:0] RG_DST  = 3'd1;
    localparam logic [2:0] RG_RLD  = 3'd2;
    localparam logic [2:0] RG_CTL  = 3'd3;
    localparam logic [2:0] RG_TRIG = 3'd4;

    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RD, ST_WR} dma_st_e;
endpackage

// File: rtl/dmac_trig.sv
module dmac_trig #(
    parameter int IRQ_N = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sw_set,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    input  logic [IRQ_N-1:0] irq,
    output logic             pend
);
    typedef struct packed {
        logic             pend;
        logic [IRQ_N-1:0] prev;
    } trig_t;

    trig_t t_q, t_d;
    logic  rise;

    always_comb begin
        t_d      = t_q;
        t_d.prev = irq;
        rise     = irq[sel] & ~t_q.prev[sel];
        if (clr)           t_d.pend = 1'b0;
        if (sw_set | rise) t_d.pend = 1'b1;
        if (!en)           t_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign pend = t_q.pend;

    // R9: a waiting request is kept (not duplicated) until it is taken
    p_merge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.pend && !clr && en) |=> t_q.pend);
    // R7: a disabled channel holds no request
    p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !t_q.pend);
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan #(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 16,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              done,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              word,
    output logic              en,
    output logic [SEL_W-1:0]  sel,
    output logic              sw_set
);
    import dmac_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] fwd;
        logic [CNT_W-1:0]  rld;
        logic [CNT_W-1:0]  cnt;
        logic              en;
        logic              word;
        logic              s_inc;
        logic              d_inc;
        logic              rpt;
        logic [SEL_W-1:0]  sel;
    } chan_t;

    chan_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        sw_set = 1'b0;
        if (done) begin
            if (r_q.cnt == '0) begin
                r_d.cnt = r_q.rld;
                r_d.fwd = '0;
                if (!r_q.rpt) r_d.en = 1'b0;
            end else begin
                r_d.cnt = r_q.cnt - 1'b1;
                if (r_q.s_inc | r_q.d_inc)
                    r_d.fwd = r_q.fwd + {{(ADDR_W-2){1'b0}}, r_q.word, ~r_q.word};
            end
        end
        if (cfg_we) begin
            case (cfg_sel)
                RG_SRC: begin r_d.src = cfg_wdata; r_d.fwd = '0; end
                RG_DST: begin r_d.dst = cfg_wdata; r_d.fwd = '0; end
                RG_RLD: begin
                    r_d.rld = cfg_wdata[CNT_W-1:0];
                    r_d.cnt = cfg_wdata[CNT_W-1:0];
                    r_d.fwd = '0;
                end
                RG_CTL: begin
                    r_d.en    = cfg_wdata[0];
                    r_d.word  = cfg_wdata[1];
                    r_d.s_inc = cfg_wdata[2];
                    r_d.d_inc = cfg_wdata[3];
                    r_d.rpt   = cfg_wdata[4];
                    r_d.sel   = cfg_wdata[5 +: SEL_W];
                end
                RG_TRIG: sw_set = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_addr = r_q.s_inc ? r_q.src + r_q.fwd : r_q.src;
    assign wr_addr = r_q.d_inc ? r_q.dst + r_q.fwd : r_q.dst;
    assign word    = r_q.word;
    assign en      = r_q.en;
    assign sel     = r_q.sel;

    // R6: underflow without repeat stops the channel
    p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && r_q.cnt == '0 && !r_q.rpt && !cfg_we) |=> !r_q.en);
    // R6: a transfer above zero decrements the counter by one
    p_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && r_q.cnt != '0 && !cfg_we) |=> (r_q.cnt == $past(r_q.cnt) - 1'b1));
endmodule

// File: rtl/dmac_top.sv
module dmac_top #(
    parameter int ADDR_W = dmac_pkg::DMA_AW,
    parameter int CNT_W  = dmac_pkg::DMA_CW,
    parameter int IRQ_N  = dmac_pkg::DMA_IRQN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_ch,
    input  logic [2:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic [IRQ_N-1:0]  irq_in,
    input  logic              bus_gnt,
    input  logic [15:0]       bus_rdata,
    output logic              bus_req,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_word,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [15:0]       bus_wdata,
    output logic [1:0]        ch_en
);
    import dmac_pkg::*;

    localparam int NCH   = DMA_NCH;
    localparam int CH_W  = $clog2(NCH);
    localparam int SEL_W = $clog2(IRQ_N);

    typedef struct packed {
        dma_st_e         st;
        logic [CH_W-1:0] ch;
        logic [7:0]      lo;
        logic [7:0]      hi;
    } fsm_t;

    fsm_t f_q, f_d;

    logic [ADDR_W-1:0] rd_a [NCH];
    logic [ADDR_W-1:0] wr_a [NCH];
    logic [SEL_W-1:0]  sel_a [NCH];
    logic [NCH-1:0]    word_v, en_v, sw_v, pend_v, clr_v, done_v;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dmac_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (cfg_we && (int'(cfg_ch) == g)),
            .cfg_sel   (cfg_sel),
            .cfg_wdata (cfg_wdata),
            .done      (done_v[g]),
            .rd_addr   (rd_a[g]),
            .wr_addr   (wr_a[g]),
            .word      (word_v[g]),
            .en        (en_v[g]),
            .sel       (sel_a[g]),
            .sw_set    (sw_v[g])
        );
        dmac_trig #(.IRQ_N(IRQ_N), .SEL_W(SEL_W)) u_trig (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en_v[g]),
            .sw_set (sw_v[g]),
            .clr    (clr_v[g]),
            .sel    (sel_a[g]),
            .irq    (irq_in),
            .pend   (pend_v[g])
        );
    end

    always_comb begin
        f_d    = f_q;
        clr_v  = '0;
        done_v = '0;
        case (f_q.st)
            ST_IDLE: begin
                for (int i = NCH - 1; i >= 0; i--) begin
                    if (pend_v[i]) begin
                        f_d.ch = CH_W'(i);
                        f_d.st = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                if (bus_gnt) begin
                    clr_v[f_q.ch] = 1'b1;
                    f_d.st        = ST_RD;
                end
            end
            ST_RD: begin
                f_d.lo = bus_rdata[7:0];
                f_d.hi = word_v[f_q.ch] ? bus_rdata[15:8] : 8'h00;
                f_d.st = ST_WR;
            end
            default: begin
                done_v[f_q.ch] = 1'b1;
                f_d.st         = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: ST_IDLE, default: '0};
        else        f_q <= f_d;
    end

    assign bus_req   = (f_q.st != ST_IDLE);
    assign bus_rd    = (f_q.st == ST_RD);
    assign bus_wr    = (f_q.st == ST_WR);
    assign bus_word  = word_v[f_q.ch];
    assign bus_addr  = (f_q.st == ST_RD) ? rd_a[f_q.ch] : wr_a[f_q.ch];
    assign bus_wdata = {f_q.hi, f_q.lo};
    assign ch_en     = en_v;

    // R3: a read cycle only follows a granted request
    p_rd_after_gnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> $past(bus_gnt));
    // R3: a write cycle directly follows the read cycle
    p_wr_after_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> $past(bus_rd));
    // R8: channel 0 wins whenever it is waiting at arbitration
    p_low_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == ST_IDLE && pend_v[0]) |=> (f_q.ch == '0));
    // R4: byte transfers drive a zero upper byte
    p_hi_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_word) |-> (bus_wdata[15:8] == 8'h00));
endmodule

// File: tb/tb_dmac_top.sv
`timescale 1ns/1ps
module tb_dmac_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we, cfg_ch, bus_gnt;
    logic [2:0]  cfg_sel;
    logic [19:0] cfg_wdata;
    logic [7:0]  irq_in;
    logic [15:0] bus_rdata, bus_wdata;
    logic        bus_req, bus_rd, bus_wr, bus_word;
    logic [19:0] bus_addr;
    logic [1:0]  ch_en;

    typedef struct {
        logic [19:0] ra;
        logic [19:0] wa;
        logic [15:0] wd;
    } exp_t;
    exp_t exp_q[$];

    int  n_chk = 0, n_fail = 0;
    bit  finished = 0;
    logic [19:0] last_ra = '0;

    always #10 clk = ~clk;

    function automatic logic [15:0] memf(input logic [19:0] a);
        return a[15:0] ^ 16'hA5C3;
    endfunction
    assign bus_rdata = memf(bus_addr);

    dmac_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .irq_in(irq_in),
        .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .bus_req(bus_req),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ch_en(ch_en)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic ch, input logic [2:0] sel, input logic [19:0] d);
        cfg_ch = ch; cfg_sel = sel; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push(input logic [19:0] ra, input logic [19:0] wa, input bit word);
        exp_t e;
        logic [15:0] m;
        m    = memf(ra);
        e.ra = ra;
        e.wa = wa;
        e.wd = word ? m : {8'h00, m[7:0]};
        exp_q.push_back(e);
    endtask

    task automatic pulse_irq(input int line);
        irq_in[line] = 1'b1;
        @(negedge clk);
        irq_in[line] = 1'b0;
    endtask

    // monitor: pops one expected item per write cycle
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && bus_rd) last_ra = bus_addr;
        if (rst_n && bus_wr) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9", "unexpected transfer", {12'h0, bus_addr}, 32'h0);
            end else begin
                e = exp_q.pop_front();
                chk(last_ra == e.ra, "R5", "read address", {12'h0, last_ra}, {12'h0, e.ra});
                chk(bus_addr == e.wa, "R5", "write address", {12'h0, bus_addr}, {12'h0, e.wa});
                chk(bus_wdata == e.wd, "R4", "write data", {16'h0, bus_wdata}, {16'h0, e.wd});
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R3 watchdog act=hung exp=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_ch = 1'b0; cfg_sel = '0;
        cfg_wdata = '0; irq_in = '0; bus_gnt = 1'b1;
        repeat (3) @(negedge clk);
        chk(!bus_req && !bus_rd && !bus_wr, "R1", "bus idle in reset", {29'h0, bus_req, bus_rd, bus_wr}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_req && !bus_rd && !bus_wr, "R1", "bus idle after reset", {29'h0, bus_req, bus_rd, bus_wr}, 32'h0);
        chk(ch_en == 2'b00, "R1", "enables after reset", {30'h0, ch_en}, 32'h0);

        // channel 0: word, source increments, three transfers then stop
        wr(1'b0, 3'd0, 20'h10000);
        wr(1'b0, 3'd1, 20'h20000);
        wr(1'b0, 3'd2, 20'd2);
        wr(1'b0, 3'd3, 20'h07);
        chk(ch_en == 2'b01, "R2", "enable from control", {30'h0, ch_en}, 32'h1);
        for (int i = 0; i < 3; i++) begin
            push(20'h10000 + 20'(2 * i), 20'h20000, 1'b1);
            wr(1'b0, 3'd4, '0);
            repeat (6) @(negedge clk);
        end
        chk(ch_en[0] == 1'b0, "R6", "stop after reload+1 transfers", {31'h0, ch_en[0]}, 32'h0);
        chk(exp_q.size() == 0, "R3", "all word transfers seen", exp_q.size(), 32'h0);

        // disabled channel drops the trigger and does not remember it
        wr(1'b0, 3'd4, '0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(!bus_req, "R7", "no request while disabled", {31'h0, bus_req}, 32'h0);
        end
        wr(1'b0, 3'd3, 20'h07);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!bus_req, "R7", "dropped request not replayed", {31'h0, bus_req}, 32'h0);
        end

        // channel 1: byte, destination increments, repeat, line 2
        wr(1'b1, 3'd0, 20'h30005);
        wr(1'b1, 3'd1, 20'h40000);
        wr(1'b1, 3'd2, 20'd1);
        wr(1'b1, 3'd3, 20'h59);
        for (int i = 0; i < 3; i++) begin
            push(20'h30005, 20'h40000 + ((i == 1) ? 20'd1 : 20'd0), 1'b0);
            pulse_irq(2);
            repeat (6) @(negedge clk);
        end
        chk(ch_en[1] == 1'b1, "R6", "repeat keeps channel enabled", {31'h0, ch_en[1]}, 32'h1);
        chk(exp_q.size() == 0, "R7", "selected line served", exp_q.size(), 32'h0);
        pulse_irq(3);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(!bus_req, "R7", "other line ignored", {31'h0, bus_req}, 32'h0);
        end

        // grant withheld: simultaneous requests, channel 0 triggered twice
        bus_gnt = 1'b0;
        push(20'h10000, 20'h20000, 1'b1);
        push(20'h30005, 20'h40001, 1'b0);
        irq_in[2] = 1'b1;
        wr(1'b0, 3'd4, '0);
        irq_in[2] = 1'b0;
        wr(1'b0, 3'd4, '0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(bus_req && !bus_rd && !bus_wr, "R3", "wait for grant", {29'h0, bus_req, bus_rd, bus_wr}, 32'h4);
        end
        bus_gnt = 1'b1;
        repeat (12) @(negedge clk);
        chk(exp_q.size() == 0, "R8", "both channels served in order", exp_q.size(), 32'h0);
        chk(!bus_req, "R3", "bus released", {31'h0, bus_req}, 32'h0);
        chk(exp_q.size() == 0, "R9", "merged requests give one transfer", exp_q.size(), 32'h0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule